// File: doc/BRIEF.md
# Serial Memory Slave Pin Front-End

This block sits between the pins of a serial memory slave and its command core. It works from a fast system clock and oversamples the serial clock, chip select, pause and write-protect pins. From these it decides when the device is selected and whether a transfer is paused. It collects incoming bits on one, two or four data lines into bytes, and it drives outgoing bits on the chosen lines with the matching output enables. The core selects the lane width, the direction of the current phase and whether a quad operation is running. The core also supplies the bits to send and reads back the completed bytes.

The block also works out the protection decisions from the pin level and a protect-enable bit that the core holds. With protect-enable clear, the pin guards only the first status register, and it stops doing so while a quad operation uses it as a data line. With protect-enable set, a low pin blocks every write and erase. Quad transfers are then refused entirely.

Top module: `spfe_top`

## Requirements
- R1: While cs_ni is high, every bit of io_oe_o is 0 and rx_valid_o stays 0.
- R2: After reset, no bit is taken and no output is enabled until cs_ni has been seen high at least once; a select that is already low at reset does not count.
- R3: In an input phase (out_phase_i=0), each rising sclk_i edge shifts in the lanes, first bit most significant. Lane code 0 takes io_i[0]. Code 1 takes io_i[1] then io_i[0]. Code 2 takes io_i[3] down to io_i[0]. After 8 bits rx_data_o holds the byte and rx_valid_o is high for exactly one clock.
- R4: In an output phase, each falling sclk_i edge loads io_o and pulses tx_adv_o in that cycle. Code 0 places tx_bits_i[0] on io_o[1]. Code 1 places tx_bits_i[1:0] on io_o[1:0]. Code 2 places tx_bits_i[3:0] on io_o[3:0].
- R5: A low hold_ni during a select starts a pause only while sclk_i is low. While paused, sclk_i edges are ignored and io_oe_o is 0. A high hold_ni ends the pause, and the byte continues from the bit where it stopped.
- R6: While quad_op_i is high, hold_ni cannot start a pause.
- R7: In an output phase io_oe_o is 4'b0010 for lane code 0, 4'b0011 for code 1 and 4'b1111 for code 2.
- R8: With wpe_i=0, sr1_lock_o equals (wp_ni low and quad_op_i low), wr_lock_o is 0 and quad_block_o is 0.
- R9: With wpe_i=1, wr_lock_o and sr1_lock_o both equal wp_ni low and quad_block_o is 1. Transfers with lane code 2 then take no bits and enable no outputs.
- R10: A rise of cs_ni in the middle of a byte discards the partial bits, and the next select starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin level |
| cs_ni | input | 1 | Active-low chip select pin |
| hold_ni | input | 1 | Active-low pause pin |
| wp_ni | input | 1 | Active-low write-protect pin |
| io_i | input | 4 | Data line levels seen at the pins |
| lane_i | input | 2 | Lane width code: 0 one line, 1 two lines, 2 four lines |
| out_phase_i | input | 1 | 1 when the current phase drives data out |
| quad_op_i | input | 1 | Core has a quad read or quad load in progress |
| wpe_i | input | 1 | Protect-enable bit held by the core |
| tx_bits_i | input | 4 | Next bits to drive, low lanes used for narrow widths |
| io_o | output | 4 | Data line output values |
| io_oe_o | output | 4 | Per-line output enables |
| tx_adv_o | output | 1 | Pulse: current tx bits were taken |
| rx_data_o | output | 8 | Last completed byte |
| rx_valid_o | output | 1 | One-clock pulse when rx_data_o updates |
| wr_lock_o | output | 1 | All writes, programs and erases blocked |
| sr1_lock_o | output | 1 | Writes to the first status register blocked |
| quad_block_o | output | 1 | Quad operations refused |

## Verification
The assertions assume that the pins change only between system clock edges. They also assume that sclk_i stays at each level for at least one clock, so that every serial edge is seen as a single rise or fall. They further take lane_i, out_phase_i and quad_op_i as steady within a byte, which the core guarantees. The bench drives every input on the falling system clock edge and holds each serial clock level for two clocks. It changes lane and direction only between bytes and while chip select is high or the serial clock is idle.

// File: rtl/spfe_pkg.sv
package spfe_pkg;
   typedef enum logic [1:0] {
      LANE_X1 = 2'd0,
      LANE_X2 = 2'd1,
      LANE_X4 = 2'd2
   } lane_e;

   function automatic logic [3:0] lane_oe_pattern(lane_e l);
      case (l)
         LANE_X2: return 4'b0011;
         LANE_X4: return 4'b1111;
         default: return 4'b0010;
      endcase
   endfunction
endpackage

// File: rtl/spfe_edge.sv
module spfe_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic rise_o,
   output logic fall_o
);
   logic sig_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q <= 1'b0;
      else         sig_q <= sig_i;
   end

   assign rise_o = sig_i & ~sig_q;
   assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/spfe_hold.sv
module spfe_hold (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel_i,
   input  logic hold_ni,
   input  logic sclk_i,
   input  logic quad_op_i,
   output logic paused_o
);
   logic paused_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  paused_q <= 1'b0;
      else if (!sel_i || hold_ni)   paused_q <= 1'b0;
      else if (!sclk_i && !quad_op_i) paused_q <= 1'b1;
   end

   assign paused_o = paused_q;

   // R5: a pause only begins in a cycle where the serial clock was low
   p_pause_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(paused_q) |-> $past(!sclk_i));

   // R6: a quad operation never lets a pause begin
   p_pause_quad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(paused_q) |-> $past(!quad_op_i));

   // R5: the pause always ends once the pin is released
   p_pause_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_ni |=> !paused_q);
endmodule

// File: rtl/spfe_shift.sv
module spfe_shift
   import spfe_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              en_i,
   input  lane_e             lane_i,
   input  logic [3:0]        io_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);
   localparam int unsigned CW = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 4 || (DATA_W % 4) != 0) begin : g_bad_width
         $error("spfe_shift: DATA_W must be a nonzero multiple of 4");
      end
   endgenerate

   logic [DATA_W-1:0] sr_q, sr_d, data_q;
   logic [CW-1:0]     cnt_q, cnt_d, step;
   logic              valid_q;

   always_comb begin
      case (lane_i)
         LANE_X2: begin
            sr_d = {sr_q[DATA_W-3:0], io_i[1:0]};
            step = CW'(2);
         end
         LANE_X4: begin
            sr_d = {sr_q[DATA_W-5:0], io_i[3:0]};
            step = CW'(4);
         end
         default: begin
            sr_d = {sr_q[DATA_W-2:0], io_i[0]};
            step = CW'(1);
         end
      endcase
      cnt_d = cnt_q + step;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q    <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (!sel_i) begin
            sr_q  <= '0;
            cnt_q <= '0;
         end else if (en_i) begin
            sr_q <= sr_d;
            if (cnt_d >= CW'(DATA_W)) begin
               cnt_q   <= '0;
               data_q  <= sr_d;
               valid_q <= 1'b1;
            end else begin
               cnt_q <= cnt_d;
            end
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;

   // R3: the bit counter never reaches a full word
   p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CW'(DATA_W));

   // R3: the completion pulse lasts one cycle
   p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |=> !valid_q);

   // R10: a deselect clears any partial count
   p_desel_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i |=> cnt_q == '0);
endmodule

// File: rtl/spfe_guard.sv
module spfe_guard (
   input  logic wpe_i,
   input  logic wp_ni,
   input  logic quad_op_i,
   output logic wr_lock_o,
   output logic sr1_lock_o,
   output logic quad_block_o
);
   logic pin_low;

   assign pin_low      = ~wp_ni;
   assign wr_lock_o    = wpe_i & pin_low;
   assign sr1_lock_o   = wpe_i ? pin_low : (pin_low & ~quad_op_i);
   assign quad_block_o = wpe_i;
endmodule

// File: rtl/spfe_top.sv
module spfe_top
   import spfe_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              cs_ni,
   input  logic              hold_ni,
   input  logic              wp_ni,
   input  logic [LANES-1:0]  io_i,
   input  logic [1:0]        lane_i,
   input  logic              out_phase_i,
   input  logic              quad_op_i,
   input  logic              wpe_i,
   input  logic [LANES-1:0]  tx_bits_i,
   output logic [LANES-1:0]  io_o,
   output logic [LANES-1:0]  io_oe_o,
   output logic              tx_adv_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              wr_lock_o,
   output logic              sr1_lock_o,
   output logic              quad_block_o
);
   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("spfe_top: LANES must be 4");
      end
   endgenerate

   lane_e lane;
   logic  seen_high_q, sel, paused, rise, fall;
   logic  lane_ok, rx_en, drive_ok;
   logic [LANES-1:0] out_q;

   assign lane = lane_e'(lane_i);

   // arming: a select counts only after the pin was seen high once
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    seen_high_q <= 1'b0;
      else if (cs_ni) seen_high_q <= 1'b1;
   end

   assign sel     = seen_high_q & ~cs_ni;
   assign lane_ok = ~(wpe_i & (lane == LANE_X4));

   spfe_edge u_sclk_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sclk_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   spfe_hold u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel),
      .hold_ni   (hold_ni),
      .sclk_i    (sclk_i),
      .quad_op_i (quad_op_i),
      .paused_o  (paused)
   );

   assign rx_en    = rise & sel & ~paused & ~out_phase_i & lane_ok;
   assign drive_ok = sel & ~paused & out_phase_i & lane_ok;

   spfe_shift #(.DATA_W(DATA_W)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .en_i    (rx_en),
      .lane_i  (lane),
      .io_i    (io_i),
      .data_o  (rx_data_o),
      .valid_o (rx_valid_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q <= '0;
      end else if (fall && drive_ok) begin
         case (lane)
            LANE_X2: out_q <= {2'b00, tx_bits_i[1:0]};
            LANE_X4: out_q <= tx_bits_i;
            default: out_q <= {2'b00, tx_bits_i[0], 1'b0};
         endcase
      end
   end

   assign io_o     = out_q;
   assign io_oe_o  = drive_ok ? lane_oe_pattern(lane) : '0;
   assign tx_adv_o = fall & drive_ok;

   spfe_guard u_guard (
      .wpe_i        (wpe_i),
      .wp_ni        (wp_ni),
      .quad_op_i    (quad_op_i),
      .wr_lock_o    (wr_lock_o),
      .sr1_lock_o   (sr1_lock_o),
      .quad_block_o (quad_block_o)
   );

   // R1: nothing is driven while deselected
   p_oe_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_ni |-> io_oe_o == '0);

   // R2: a completed byte implies an armed select in the cycle before
   p_armed_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o |-> $past(seen_high_q && !cs_ni));

   // R7: the upper lines drive only in four-line phases
   p_upper_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|io_oe_o[3:2]) |-> (lane == LANE_X4));

   // R8: a full lock always includes the status register lock
   p_lock_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lock_o |-> sr1_lock_o);

   // R9: quad phases are refused while protection is enabled
   p_quad_refused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      quad_block_o |-> !io_oe_o[3]);
endmodule

// File: tb/spfe_top_tb_top.sv
`timescale 1ns/1ps
module spfe_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic [3:0] io_in = '0, tx_bits = '0;
   logic [1:0] lane = 2'd0;
   logic       out_phase = 1'b0, quad_op = 1'b0, wpe = 1'b0;
   logic [3:0] io_out, io_oe;
   logic       tx_adv, rx_valid, wr_lock, sr1_lock, quad_block;
   logic [7:0] rx_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   spfe_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
      .hold_ni(hold_n), .wp_ni(wp_n), .io_i(io_in), .lane_i(lane),
      .out_phase_i(out_phase), .quad_op_i(quad_op), .wpe_i(wpe),
      .tx_bits_i(tx_bits), .io_o(io_out), .io_oe_o(io_oe),
      .tx_adv_o(tx_adv), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
      .wr_lock_o(wr_lock), .sr1_lock_o(sr1_lock), .quad_block_o(quad_block)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one serial bit: low then high, returns after the rise is sampled
   task automatic sbit(input logic [3:0] v);
      @(negedge clk); sclk = 1'b0; io_in = v;
      @(negedge clk); sclk = 1'b1;
      @(negedge clk);
   endtask

   // send a byte msb-first; reports pulses seen and the last captured byte
   task automatic send_byte(input int nb, input logic [7:0] v, input int first, input int last,
                            output int pulses, output int last_hit, output logic [7:0] got);
      pulses = 0; last_hit = 0; got = '0;
      for (int i = first; i <= last; i++) begin
         logic [7:0] sh;
         sh = v >> (8 - nb * (i + 1));
         sbit(sh[3:0] & 4'((1 << nb) - 1));
         if (rx_valid) begin
            pulses++;
            got = rx_data;
            if (i == 8 / nb - 1) last_hit = 1;
         end
      end
   endtask

   task automatic cs_pulse();
      @(negedge clk); cs_n = 1'b1; sclk = 1'b0;
      @(negedge clk);
      @(negedge clk); cs_n = 1'b0;
   endtask

   initial begin
      int p, h;
      logic [7:0] g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(rx_valid == 1'b0, "R2 reset valid", rx_valid, 0);
      out_phase = 1'b1;
      #1 chk(io_oe == 4'b0000, "R2 unarmed oe", io_oe, 0);
      out_phase = 1'b0;
      // select low since reset: not armed
      send_byte(1, 8'hA5, 0, 7, p, h, g);
      chk(p == 0, "R2 unarmed bits ignored", p, 0);
      // deselected: no drive
      @(negedge clk); cs_n = 1'b1; out_phase = 1'b1;
      #1 chk(io_oe == 4'b0000, "R1 deselect oe", io_oe, 0);
      @(negedge clk); out_phase = 1'b0; cs_n = 1'b0;
      send_byte(1, 8'hA5, 0, 7, p, h, g);
      chk(p == 1 && h == 1 && g == 8'hA5, "R2 armed byte", g, 8'hA5);

      // exhaustive receive sweeps over the three lane widths
      for (int l = 0; l < 3; l++) begin
         lane = 2'(l);
         cs_pulse();
         for (int v = 0; v < 256; v++) begin
            send_byte(1 << l, 8'(v), 0, 8 / (1 << l) - 1, p, h, g);
            chk(p == 1 && h == 1 && g == 8'(v), "R3 receive sweep", g, v);
         end
      end

      // deselect mid-byte discards partial bits
      lane = 2'd0;
      send_byte(1, 8'hFF, 0, 3, p, h, g);
      cs_pulse();
      send_byte(1, 8'h3C, 0, 7, p, h, g);
      chk(p == 1 && h == 1 && g == 8'h3C, "R10 partial discarded", g, 8'h3C);

      // pause mid-byte, junk edges ignored, resume
      send_byte(1, 8'hC6, 0, 2, p, h, g);
      @(negedge clk); hold_n = 1'b0;
      p = 0;
      for (int k = 0; k < 6; k++) begin
         sbit(4'b0001);
         if (rx_valid) p++;
      end
      chk(p == 0, "R5 edges ignored while paused", p, 0);
      @(negedge clk); out_phase = 1'b1;
      #1 chk(io_oe == 4'b0000, "R5 paused oe", io_oe, 0);
      @(negedge clk); out_phase = 1'b0; sclk = 1'b0;
      @(negedge clk); hold_n = 1'b1;
      @(negedge clk);
      send_byte(1, 8'hC6, 3, 7, p, h, g);
      chk(p == 1 && h == 1 && g == 8'hC6, "R5 resumed byte", g, 8'hC6);

      // hold has no effect during a quad operation
      lane = 2'd2; quad_op = 1'b1;
      cs_pulse();
      @(negedge clk); hold_n = 1'b0;
      send_byte(4, 8'h5A, 0, 1, p, h, g);
      chk(p == 1 && h == 1 && g == 8'h5A, "R6 hold ignored in quad", g, 8'h5A);
      @(negedge clk); hold_n = 1'b1; quad_op = 1'b0;

      // output path, all lane widths and tx values
      out_phase = 1'b1;
      for (int l = 0; l < 3; l++) begin
         lane = 2'(l);
         cs_pulse();
         for (int t = 0; t < 16; t++) begin
            logic [3:0] eo, ev;
            eo = (l == 0) ? 4'b0010 : (l == 1) ? 4'b0011 : 4'b1111;
            ev = (l == 0) ? {2'b00, 4'(t) & 4'b0001, 1'b0} << 0 : (l == 1) ? (4'(t) & 4'b0011) : 4'(t);
            if (l == 0) ev = {2'b00, t[0], 1'b0};
            @(negedge clk); tx_bits = 4'(t); sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
            #1 chk(tx_adv == 1'b1, "R4 advance pulse", tx_adv, 1);
            @(negedge clk);
            chk(io_oe == eo, "R7 enable pattern", io_oe, eo);
            chk((io_out & eo) == ev, "R4 falling-edge data", io_out & eo, ev);
         end
      end
      out_phase = 1'b0;

      // protection truth table
      for (int w = 0; w < 2; w++)
         for (int pn = 0; pn < 2; pn++)
            for (int q = 0; q < 2; q++) begin
               logic ew, es;
               @(negedge clk); wpe = w[0]; wp_n = pn[0]; quad_op = q[0];
               ew = w[0] & ~pn[0];
               es = w[0] ? ~pn[0] : (~pn[0] & ~q[0]);
               #1;
               chk(wr_lock == ew, w[0] ? "R9 write lock" : "R8 write lock", wr_lock, ew);
               chk(sr1_lock == es, w[0] ? "R9 sr1 lock" : "R8 sr1 lock", sr1_lock, es);
               chk(quad_block == w[0], w[0] ? "R9 quad block" : "R8 quad block", quad_block, w);
            end
      @(negedge clk); quad_op = 1'b0; wp_n = 1'b1; wpe = 1'b1;

      // quad transfers refused with protect-enable set
      lane = 2'd2;
      cs_pulse();
      send_byte(4, 8'h96, 0, 1, p, h, g);
      chk(p == 0, "R9 quad receive refused", p, 0);
      @(negedge clk); out_phase = 1'b1;
      #1 chk(io_oe == 4'b0000, "R9 quad drive refused", io_oe, 0);
      lane = 2'd0;
      #1 chk(io_oe == 4'b0010, "R9 single lane still allowed", io_oe, 4'b0010);
      @(negedge clk); out_phase = 1'b0; wpe = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule